// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

Two processors share this block to signal each other over six independent one-way channels. Each processor reaches it through its own single-cycle register port, which carries four registers: a control register, a mask register, a write-only set/clear register and a read-only status register. Both ports have the same layout.

Each side owns one flag per channel. A processor raises its own flag for a channel to announce that a message is waiting. The other processor reads that flag, consumes the message, and then lowers the flag through its own set/clear register to acknowledge it.

Each side drives two interrupt lines. The receive line is asserted while a peer flag is raised on an unmasked channel. The transmit line is asserted while one of the side's own flags is low on an unmasked channel, meaning that channel is free to send on. Each line is gated by its own per-channel mask and its own global enable. Message payload storage, clocking and power control are not part of this block.

Top module: `mbx_flag_ctrl`

## Requirements
- R1: After reset, on both ports: the status register (address 3) reads 0, the control register (address 0) reads 0, the mask register (address 1) reads 0x003F003F (every channel masked), and all four interrupt outputs are 0.
- R2: The control register keeps bit 0 (receive enable) and bit 1 (transmit enable). The mask register keeps bits 5:0 (receive mask, channel n at bit n-1) and bits 21:16 (transmit mask). Written values read back on the same port, and all other bits read 0.
- R3: A write to address 2 with bit 16+n-1 set raises the writer's own flag for channel n. The writer's status bit n-1 shows it from the cycle after the write.
- R4: A write to address 2 with bit n-1 set lowers the peer's flag for channel n. It does not touch the writer's own flag.
- R5: Zero bits written to address 2 change no flag. Address 2 always reads 0. A cycle with no set/clear write leaves every flag unchanged.
- R6: If one side sets its flag for a channel in the same cycle that the peer clears it, the flag ends up set.
- R7: The receive interrupt of a side equals its receive enable ANDed with the OR, over all channels, of (peer flag AND NOT receive-mask bit).
- R8: The transmit interrupt of a side equals its transmit enable ANDed with the OR, over all channels, of (NOT own flag AND NOT transmit-mask bit).
- R9: The two banks are independent. A flag, mask or enable written on one port appears in that port's registers only. Each side's status register shows only that side's own flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| p1_sel | input | 1 | Processor 1 register access strobe |
| p1_wr | input | 1 | Processor 1 write (1) or read (0) |
| p1_addr | input | 2 | Processor 1 register address |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data, combinational |
| p1_rx_irq | output | 1 | Processor 1 receive-occupied interrupt |
| p1_tx_irq | output | 1 | Processor 1 transmit-free interrupt |
| p2_sel | input | 1 | Processor 2 register access strobe |
| p2_wr | input | 1 | Processor 2 write (1) or read (0) |
| p2_addr | input | 2 | Processor 2 register address |
| p2_wdata | input | 32 | Processor 2 write data |
| p2_rdata | output | 32 | Processor 2 read data, combinational |
| p2_rx_irq | output | 1 | Processor 2 receive-occupied interrupt |
| p2_tx_irq | output | 1 | Processor 2 transmit-free interrupt |

## Verification
A corrupted flag shows up in the owner's status read in the cycle after the bad write. Because the interrupt logic is purely combinational, it also shows up at once on the peer's receive line and on the owner's transmit line wherever that channel is unmasked. A wrong mask or enable bit can be seen in the register read-back and in an interrupt that fails to follow flag changes. The bench therefore checks status, read-back and interrupt lines after each write, and it pairs set and clear on the same channel in one cycle to expose a lost priority.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 2;
    localparam int HI_LSB   = 16;   // upper field base: transmit mask and set field

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_MASK   = 2'd1,
        REG_SETCLR = 2'd2,
        REG_STAT   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mbx_side_regs.sv
module mbx_side_regs #(
    parameter int NUM_CH = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel,
    input  logic                      wr,
    input  logic [mbx_pkg::ADDR_W-1:0] addr,
    input  logic [mbx_pkg::DATA_W-1:0] wdata,
    input  logic [NUM_CH-1:0]         own_flags,
    output logic [mbx_pkg::DATA_W-1:0] rdata,
    output logic                      rx_en,
    output logic                      tx_en,
    output logic [NUM_CH-1:0]         rx_mask,
    output logic [NUM_CH-1:0]         tx_mask,
    output logic [NUM_CH-1:0]         set_own,
    output logic [NUM_CH-1:0]         clr_peer
);
    import mbx_pkg::*;

    reg_sel_e reg_sel;
    logic     wr_hit;
    logic     unused_wdata;

    assign reg_sel      = reg_sel_e'(addr);
    assign wr_hit       = sel && wr;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en   <= 1'b0;
            tx_en   <= 1'b0;
            rx_mask <= '1;
            tx_mask <= '1;
        end else if (wr_hit) begin
            if (reg_sel == REG_CTRL) begin
                rx_en <= wdata[0];
                tx_en <= wdata[1];
            end
            if (reg_sel == REG_MASK) begin
                rx_mask <= wdata[NUM_CH-1:0];
                tx_mask <= wdata[HI_LSB +: NUM_CH];
            end
        end
    end

    // write-1 pulses toward the flag banks
    always_comb begin
        set_own  = '0;
        clr_peer = '0;
        if (wr_hit && reg_sel == REG_SETCLR) begin
            set_own  = wdata[HI_LSB +: NUM_CH];
            clr_peer = wdata[NUM_CH-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        unique case (reg_sel)
            REG_CTRL: begin
                rdata[0] = rx_en;
                rdata[1] = tx_en;
            end
            REG_MASK: begin
                rdata[NUM_CH-1:0]       = rx_mask;
                rdata[HI_LSB +: NUM_CH] = tx_mask;
            end
            REG_SETCLR: rdata = '0;
            REG_STAT:   rdata[NUM_CH-1:0] = own_flags;
        endcase
    end
endmodule

// File: rtl/mbx_flag_bank.sv
module mbx_flag_bank #(
    parameter int NUM_CH = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] set_req,
    input  logic [NUM_CH-1:0] clr_req,
    output logic [NUM_CH-1:0] flags
);
    // set dominates a simultaneous clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_req) | set_req;
    end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] own_flags,
    input  logic [NUM_CH-1:0] peer_flags,
    input  logic [NUM_CH-1:0] rx_mask,
    input  logic [NUM_CH-1:0] tx_mask,
    input  logic              rx_en,
    input  logic              tx_en,
    output logic              rx_irq,
    output logic              tx_irq
);
    assign rx_irq = rx_en && (|(peer_flags & ~rx_mask));
    assign tx_irq = tx_en && (|(~own_flags & ~tx_mask));
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl #(
    parameter int NUM_CH = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        p1_sel,
    input  logic        p1_wr,
    input  logic [1:0]  p1_addr,
    input  logic [31:0] p1_wdata,
    output logic [31:0] p1_rdata,
    output logic        p1_rx_irq,
    output logic        p1_tx_irq,
    input  logic        p2_sel,
    input  logic        p2_wr,
    input  logic [1:0]  p2_addr,
    input  logic [31:0] p2_wdata,
    output logic [31:0] p2_rdata,
    output logic        p2_rx_irq,
    output logic        p2_tx_irq
);
    localparam int NSIDE = 2;

    logic              sel_a   [NSIDE];
    logic              wr_a    [NSIDE];
    logic [1:0]        addr_a  [NSIDE];
    logic [31:0]       wdata_a [NSIDE];
    logic [31:0]       rdata_a [NSIDE];
    logic              rxirq_a [NSIDE];
    logic              txirq_a [NSIDE];
    logic [NUM_CH-1:0] flags_a [NSIDE];
    logic [NUM_CH-1:0] set_a   [NSIDE];
    logic [NUM_CH-1:0] clr_a   [NSIDE];
    logic [NUM_CH-1:0] flag_p1;
    logic [NUM_CH-1:0] flag_p2;

    assign sel_a[0] = p1_sel;   assign sel_a[1] = p2_sel;
    assign wr_a[0]  = p1_wr;    assign wr_a[1]  = p2_wr;
    assign addr_a[0] = p1_addr; assign addr_a[1] = p2_addr;
    assign wdata_a[0] = p1_wdata; assign wdata_a[1] = p2_wdata;
    assign p1_rdata  = rdata_a[0]; assign p2_rdata  = rdata_a[1];
    assign p1_rx_irq = rxirq_a[0]; assign p2_rx_irq = rxirq_a[1];
    assign p1_tx_irq = txirq_a[0]; assign p2_tx_irq = txirq_a[1];
    assign flag_p1 = flags_a[0];
    assign flag_p2 = flags_a[1];

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        logic              rx_en, tx_en;
        logic [NUM_CH-1:0] rx_mask, tx_mask;

        mbx_side_regs #(.NUM_CH(NUM_CH)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .sel(sel_a[s]), .wr(wr_a[s]), .addr(addr_a[s]), .wdata(wdata_a[s]),
            .own_flags(flags_a[s]), .rdata(rdata_a[s]),
            .rx_en(rx_en), .tx_en(tx_en), .rx_mask(rx_mask), .tx_mask(tx_mask),
            .set_own(set_a[s]), .clr_peer(clr_a[s])
        );

        // own flag: raised by this side, lowered by the peer
        mbx_flag_bank #(.NUM_CH(NUM_CH)) u_flags (
            .clk(clk), .rst_n(rst_n),
            .set_req(set_a[s]), .clr_req(clr_a[NSIDE-1-s]),
            .flags(flags_a[s])
        );

        mbx_irq_gen #(.NUM_CH(NUM_CH)) u_irq (
            .own_flags(flags_a[s]), .peer_flags(flags_a[NSIDE-1-s]),
            .rx_mask(rx_mask), .tx_mask(tx_mask),
            .rx_en(rx_en), .tx_en(tx_en),
            .rx_irq(rxirq_a[s]), .tx_irq(txirq_a[s])
        );
    end
endmodule

// File: rtl/mbx_flag_ctrl_chk.sv
module mbx_flag_ctrl_chk #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              p1_sel,
    input logic              p1_wr,
    input logic [1:0]        p1_addr,
    input logic [31:0]       p1_wdata,
    input logic              p2_sel,
    input logic              p2_wr,
    input logic [1:0]        p2_addr,
    input logic [31:0]       p2_wdata,
    input logic              p1_rx_irq,
    input logic              p1_tx_irq,
    input logic [NUM_CH-1:0] flag_p1,
    input logic [NUM_CH-1:0] flag_p2
);
    localparam int HI = mbx_pkg::HI_LSB;

    logic p1_sc, p2_sc;
    assign p1_sc = p1_sel && p1_wr && (p1_addr == 2'd2);
    assign p2_sc = p2_sel && p2_wr && (p2_addr == 2'd2);

    // R3
    p1_set_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_sc && p1_wdata[HI]) |=> flag_p1[0]);

    // R4
    p2_clr_lowers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p2_sc && p2_wdata[0] && !(p1_sc && p1_wdata[HI])) |=> !flag_p1[0]);

    // R6
    set_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (p2_sc && p2_wdata[HI+1] && p1_sc && p1_wdata[1]) |=> flag_p2[1]);

    // R5
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!p1_sc && !p2_sc) |=> ($stable(flag_p1) && $stable(flag_p2)));

    // R7
    rx_needs_peer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p1_rx_irq |-> (|flag_p2));

    // R8
    tx_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        p1_tx_irq |-> !(&flag_p1));
endmodule

bind mbx_flag_ctrl mbx_flag_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .p1_sel(p1_sel), .p1_wr(p1_wr), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
    .p2_sel(p2_sel), .p2_wr(p2_wr), .p2_addr(p2_addr), .p2_wdata(p2_wdata),
    .p1_rx_irq(p1_rx_irq), .p1_tx_irq(p1_tx_irq),
    .flag_p1(flag_p1), .flag_p2(flag_p2)
);

// File: tb/sim_mbx_flag_ctrl.sv
module sim_mbx_flag_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] A_CTRL = 2'd0, A_MASK = 2'd1, A_SC = 2'd2, A_STAT = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p1_sel = 0, p1_wr = 0, p2_sel = 0, p2_wr = 0;
    logic [1:0]  p1_addr = 0, p2_addr = 0;
    logic [31:0] p1_wdata = 0, p2_wdata = 0;
    logic [31:0] p1_rdata, p2_rdata;
    logic        p1_rx_irq, p1_tx_irq, p2_rx_irq, p2_tx_irq;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .p1_sel(p1_sel), .p1_wr(p1_wr), .p1_addr(p1_addr), .p1_wdata(p1_wdata),
        .p1_rdata(p1_rdata), .p1_rx_irq(p1_rx_irq), .p1_tx_irq(p1_tx_irq),
        .p2_sel(p2_sel), .p2_wr(p2_wr), .p2_addr(p2_addr), .p2_wdata(p2_wdata),
        .p2_rdata(p2_rdata), .p2_rx_irq(p2_rx_irq), .p2_tx_irq(p2_tx_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // drive both ports for one edge; side enables pick which ports write
    task automatic wr2(bit en1, logic [1:0] a1, logic [31:0] d1,
                       bit en2, logic [1:0] a2, logic [31:0] d2);
        @(negedge clk);
        p1_sel = en1; p1_wr = en1; p1_addr = a1; p1_wdata = d1;
        p2_sel = en2; p2_wr = en2; p2_addr = a2; p2_wdata = d2;
        @(posedge clk); #1;
        p1_sel = 0; p1_wr = 0; p2_sel = 0; p2_wr = 0;
    endtask

    task automatic wr(int side, logic [1:0] a, logic [31:0] d);
        if (side == 1) wr2(1, a, d, 0, 0, 0);
        else           wr2(0, 0, 0, 1, a, d);
    endtask

    task automatic rd(int side, logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        if (side == 1) begin p1_sel = 1; p1_wr = 0; p1_addr = a; end
        else           begin p2_sel = 1; p2_wr = 0; p2_addr = a; end
        #1;
        d = (side == 1) ? p1_rdata : p2_rdata;
        p1_sel = 0; p2_sel = 0;
    endtask

    task automatic rd_chk(string req, int side, logic [1:0] a, logic [31:0] exp);
        logic [31:0] d;
        rd(side, a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        for (int s = 1; s <= 2; s++) begin
            rd_chk("R1 stat", s, A_STAT, 32'h0);
            rd_chk("R1 ctrl", s, A_CTRL, 32'h0);
            rd_chk("R1 mask", s, A_MASK, 32'h003F003F);
        end
        check("R1 irqs", {28'h0, p1_rx_irq, p1_tx_irq, p2_rx_irq, p2_tx_irq}, 32'h0);
    endtask

    task automatic t_regs();
        wr(1, A_CTRL, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl readback", 1, A_CTRL, 32'h3);
        rd_chk("R9 peer ctrl untouched", 2, A_CTRL, 32'h0);
        wr(2, A_MASK, 32'hFFFF_0000);
        rd_chk("R2 mask readback", 2, A_MASK, 32'h003F0000);
        rd_chk("R9 peer mask untouched", 1, A_MASK, 32'h003F003F);
        rd_chk("R5 setclr reads 0", 1, A_SC, 32'h0);
        wr(1, A_CTRL, 0);
        wr(2, A_MASK, 32'h003F003F);
    endtask

    task automatic t_setclr();
        wr(1, A_SC, 32'h0021_0000);               // p1 raises ch1 and ch6
        rd_chk("R3 own flags raised", 1, A_STAT, 32'h21);
        rd_chk("R9 peer status separate", 2, A_STAT, 32'h0);
        wr(1, A_SC, 32'h0000_0001);               // p1 clear targets p2 only
        rd_chk("R4 own flag kept", 1, A_STAT, 32'h21);
        wr(2, A_SC, 32'h0000_0001);               // p2 acknowledges ch1
        rd_chk("R4 peer clear", 1, A_STAT, 32'h20);
        wr(2, A_SC, 32'h0);
        rd_chk("R5 zero write", 1, A_STAT, 32'h20);
        rd_chk("R5 zero write peer", 2, A_STAT, 32'h0);
        wr(2, A_SC, 32'h0000_0020);
        rd_chk("R4 clear ch6", 1, A_STAT, 32'h0);
    endtask

    task automatic t_collide();
        wr2(1, A_SC, 32'h0004_0000, 1, A_SC, 32'h0000_0004);
        rd_chk("R6 set wins", 1, A_STAT, 32'h4);
        wr(2, A_SC, 32'h0000_0004);
        rd_chk("R6 later clear", 1, A_STAT, 32'h0);
    endtask

    task automatic t_irq();
        wr(2, A_CTRL, 32'h1);                     // p2 receive enable
        wr(2, A_MASK, 32'h003F001F);              // unmask ch6 receive
        check("R7 no flag", {31'h0, p2_rx_irq}, 0);
        wr(1, A_SC, 32'h0020_0000);
        check("R7 rx asserted", {31'h0, p2_rx_irq}, 1);
        check("R9 p1 rx quiet", {31'h0, p1_rx_irq}, 0);
        wr(2, A_CTRL, 32'h0);
        check("R7 enable gates", {31'h0, p2_rx_irq}, 0);
        wr(2, A_CTRL, 32'h1);
        wr(2, A_MASK, 32'h003F003F);
        check("R7 mask gates", {31'h0, p2_rx_irq}, 0);
        wr(1, A_CTRL, 32'h2);                     // p1 transmit enable
        wr(1, A_MASK, 32'h001F003F);              // unmask ch6 transmit
        check("R8 busy channel", {31'h0, p1_tx_irq}, 0);
        wr(2, A_SC, 32'h0000_0020);
        check("R8 freed channel", {31'h0, p1_tx_irq}, 1);
        wr(1, A_MASK, 32'h003F003F);
        check("R8 mask gates", {31'h0, p1_tx_irq}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_setclr();
        t_collide();
        t_irq();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule